// File: doc/BRIEF.md
# Packet Statistics Counter Bank with Read-Sequence Clear

This block keeps transmit and receive packet statistics for a network PHY. Each direction forms a group. A group holds a 32-bit packet counter and a 16-bit error packet counter, fed by single-cycle event pulses. Software, or a management bridge in front of the block, reads the counters through a synchronous read port. That port has an address, a read strobe and 16-bit registered read data. A separate saturating counter of link-loss events is also readable.

A read of a group's first register freezes a snapshot of that group, so the three registers always form a consistent set. The group is cleared only after its three registers are read in strict ascending order, with no other read strobe in between. Events that arrive while the group is frozen go on being counted. After a clear, each counter holds exactly the events seen since the snapshot was taken. Any interrupted or reordered sequence leaves the counters intact.

Top module: `pkt_stat_bank`

## Requirements
- R1: Register map. The transmit group occupies 0x639 to 0x63B and the receive group occupies 0x63C to 0x63E. Offset 0 holds packet count bits 15:0, offset 1 holds packet count bits 31:16, and offset 2 holds the 16-bit error count. Read data appears on the clock after the strobe and is zero on any cycle that follows a cycle without a strobe.
- R2: Each pulse on a packet-done input adds one to that direction's packet counter. Each pulse on a packet-error input adds one to that direction's error counter. The two directions do not affect each other.
- R3: A read of offset 0 returns the live packet count bits 15:0 and captures a snapshot of the group. Offsets 1 and 2 return the snapshot values, which later events do not change.
- R4: Three read strobes to offsets 0, 1 and 2 of one group, with no other read strobe between them, clear that group. Idle cycles between the strobes are allowed.
- R5: Any other pattern leaves the group uncleared and restarts its tracking. This covers a second offset-0 read mid-sequence, offsets out of order, a read of the other group and a read of any other address.
- R6: No event is lost. When a group clears, each of its counters becomes the number of events counted since the last snapshot, including an event in the clearing cycle.
- R7: Every counter saturates at its all-ones value instead of wrapping.
- R8: The link-loss count is 6 bits wide and increments on each link-loss pulse. It reads at 0x547 in bits 15:10, with bits 9:0 zero. Reading it clears nothing.
- R9: A read of an unmapped address returns zero and changes no state.
- R10: Synchronous active-high reset clears all counters, snapshots, sequence tracking and the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_pkt_done | input | 1 | Transmit packet completed pulse |
| tx_pkt_err | input | 1 | Transmit packet error pulse |
| rx_pkt_done | input | 1 | Receive packet completed pulse |
| rx_pkt_err | input | 1 | Receive packet error pulse |
| link_loss | input | 1 | Link-loss event pulse |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read address |
| rd_data | output | 16 | Registered read data |

## Verification
Read data is due exactly one clock after the strobe edge. An event pulse is counted at the edge that samples it, so a strobe on the next cycle already sees it. A clear takes effect at the edge of the offset-2 strobe, and the next read shows the result. The bench drives inputs on the falling edge and holds each strobe for one cycle. It compares rd_data against a behavioural model on every falling edge, and the directed reads sample one falling edge after their strobe.

// File: rtl/pstat_pkg.sv
package pstat_pkg;
  // Progress of the ascending read sequence of one group
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GOT0 = 2'd1,
    SEQ_GOT1 = 2'd2
  } seq_t;
endpackage

// File: rtl/pstat_satcnt.sv
module pstat_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] base;
  logic [W:0]   sum;

  always_comb begin
    base = load ? load_val : cnt;
    sum  = {1'b0, base} + {{W{1'b0}}, inc};
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (sum[W]) cnt <= MAXV;
    else             cnt <= sum[W-1:0];
  end

  // R7: a full counter stays full unless reloaded
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt) == MAXV && !$past(load)) |-> cnt == MAXV);
endmodule

// File: rtl/pstat_group.sv
module pstat_group
  import pstat_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int PKT_W  = 32,
  parameter int ERR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_pkt,
  input  logic              ev_err,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              hit,
  output logic [DATA_W-1:0] rd_val
);
  localparam logic [ADDR_W-1:0] A_LO  = BASE;
  localparam logic [ADDR_W-1:0] A_HI  = BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ERR = BASE + ADDR_W'(2);

  logic sel_lo, sel_hi, sel_err, clear;
  seq_t seq_q, seq_d;
  logic [PKT_W-1:0] live_pkt, snap_pkt;
  logic [ERR_W-1:0] live_err, snap_err;

  assign sel_lo  = rd_en && (rd_addr == A_LO);
  assign sel_hi  = rd_en && (rd_addr == A_HI);
  assign sel_err = rd_en && (rd_addr == A_ERR);
  assign hit     = sel_lo | sel_hi | sel_err;
  assign clear   = sel_err && (seq_q == SEQ_GOT1);

  // Live counters; on clear they restart from events seen since the snapshot
  pstat_satcnt #(.W(PKT_W)) u_pkt (
    .clk(clk), .rst(rst), .inc(ev_pkt), .load(clear),
    .load_val(live_pkt - snap_pkt), .cnt(live_pkt));

  pstat_satcnt #(.W(ERR_W)) u_err (
    .clk(clk), .rst(rst), .inc(ev_err), .load(clear),
    .load_val(live_err - snap_err), .cnt(live_err));

  // Snapshot captured on every first-register read
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      snap_pkt <= '0;
      snap_err <= '0;
    end else if (sel_lo) begin
      snap_pkt <= live_pkt;
      snap_err <= live_err;
    end
  end

  // Sequence tracker: any deviating strobe drops back to idle
  always_comb begin
    if (!rd_en)       seq_d = seq_q;
    else if (sel_lo)  seq_d = (seq_q == SEQ_IDLE) ? SEQ_GOT0 : SEQ_IDLE;
    else if (sel_hi)  seq_d = (seq_q == SEQ_GOT0) ? SEQ_GOT1 : SEQ_IDLE;
    else              seq_d = SEQ_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) seq_q <= SEQ_IDLE;
    else     seq_q <= seq_d;
  end

  always_comb begin
    rd_val = '0;
    if (sel_lo)       rd_val = live_pkt[DATA_W-1:0];
    else if (sel_hi)  rd_val = DATA_W'(snap_pkt >> DATA_W);
    else if (sel_err) rd_val = DATA_W'(snap_err);
  end

  // R3: a snapshot never exceeds the live count it was taken from
  a_r3_snap_bounded: assert property (@(posedge clk) disable iff (rst)
    (snap_pkt <= live_pkt) && (snap_err <= live_err));

  // R4: a live counter only ever drops after an error-register read
  a_r4_drop_needs_read: assert property (@(posedge clk) disable iff (rst)
    ((live_pkt < $past(live_pkt)) || (live_err < $past(live_err)))
      |-> $past(rd_en && rd_addr == A_ERR));

  // R5: an error-register read outside the sequence leaves the snapshot
  a_r5_no_clear_off_seq: assert property (@(posedge clk) disable iff (rst)
    ($past(sel_err) && $past(seq_q) != SEQ_GOT1)
      |-> (snap_pkt == $past(snap_pkt) && snap_err == $past(snap_err)));
endmodule

// File: rtl/pkt_stat_bank.sv
module pkt_stat_bank #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int PKT_W  = 32,
  parameter int ERR_W  = 16,
  parameter int LL_W   = 6,
  parameter int LL_LSB = 10,
  parameter logic [ADDR_W-1:0] FIRST_STAT_ADDR = 12'h639,
  parameter logic [ADDR_W-1:0] LINK_ADDR       = 12'h547
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_pkt_done,
  input  logic              tx_pkt_err,
  input  logic              rx_pkt_done,
  input  logic              rx_pkt_err,
  input  logic              link_loss,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NUM_GROUPS = 2;
  localparam int GROUP_SPAN = 3;

  logic [NUM_GROUPS-1:0] ev_pkt, ev_err, grp_hit;
  logic [DATA_W-1:0]     grp_val [NUM_GROUPS];
  logic [LL_W-1:0]       ll_cnt;
  logic                  ll_sel;
  logic [DATA_W-1:0]     rd_mux;

  assign ev_pkt = {rx_pkt_done, tx_pkt_done};
  assign ev_err = {rx_pkt_err,  tx_pkt_err};
  assign ll_sel = rd_en && (rd_addr == LINK_ADDR);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    pstat_group #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PKT_W(PKT_W), .ERR_W(ERR_W),
      .BASE(FIRST_STAT_ADDR + ADDR_W'(g * GROUP_SPAN))
    ) u_grp (
      .clk(clk), .rst(rst), .ev_pkt(ev_pkt[g]), .ev_err(ev_err[g]),
      .rd_en(rd_en), .rd_addr(rd_addr),
      .hit(grp_hit[g]), .rd_val(grp_val[g]));
  end

  pstat_satcnt #(.W(LL_W)) u_ll (
    .clk(clk), .rst(rst), .inc(link_loss), .load(1'b0),
    .load_val('0), .cnt(ll_cnt));

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (grp_hit[g]) rd_mux = rd_mux | grp_val[g];
    if (ll_sel) rd_mux = DATA_W'(ll_cnt) << LL_LSB;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
    else            rd_data <= '0;
  end

  // R1: no strobe, no data
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> rd_data == '0);

  // R9: unmapped reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(grp_hit) == '0 && $past(rd_addr) != LINK_ADDR)
      |-> rd_data == '0);

  // R8: link-loss register keeps the low field clear
  a_r8_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    $past(ll_sel) |-> rd_data[LL_LSB-1:0] == '0);

  // R2: at most one group answers a read
  a_r2_one_group: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grp_hit));
endmodule

// File: tb/test_pkt_stat_bank.sv
module test_pkt_stat_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_pkt_done = 0, tx_pkt_err = 0, rx_pkt_done = 0, rx_pkt_err = 0;
  logic        link_loss = 0, rd_en = 0;
  logic [11:0] rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R10";

  always #2 clk = ~clk;

  pkt_stat_bank i_pkt_stat_bank (
    .clk(clk), .rst(rst), .tx_pkt_done(tx_pkt_done), .tx_pkt_err(tx_pkt_err),
    .rx_pkt_done(rx_pkt_done), .rx_pkt_err(rx_pkt_err), .link_loss(link_loss),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  // Behavioural reference model
  longint m_lp[2], m_le[2], m_sp[2], m_se[2], m_ll;
  int     m_sq[2];
  int     m_off;
  bit     m_clr, m_ep, m_ee, m_valid;
  longint m_e, exp_q;
  localparam longint MAXP = 64'hFFFF_FFFF;
  localparam longint MAXE = 64'hFFFF;

  always @(posedge clk) begin
    if (rst) begin
      for (int h = 0; h < 2; h++) begin
        m_lp[h] = 0; m_le[h] = 0; m_sp[h] = 0; m_se[h] = 0; m_sq[h] = 0;
      end
      m_ll = 0; exp_q = 0; m_valid = 0;
    end else begin
      m_e = 0;
      for (int h = 0; h < 2; h++) begin
        m_off = int'(rd_addr) - (32'h639 + 3 * h);
        m_ep  = (h == 0) ? tx_pkt_done : rx_pkt_done;
        m_ee  = (h == 0) ? tx_pkt_err  : rx_pkt_err;
        m_clr = 0;
        if (rd_en && m_off >= 0 && m_off < 3) begin
          if (m_off == 0) begin
            m_e = m_lp[h] & 16'hFFFF;
            m_sp[h] = m_lp[h]; m_se[h] = m_le[h];
            m_sq[h] = (m_sq[h] == 0) ? 1 : 0;
          end else if (m_off == 1) begin
            m_e = (m_sp[h] >> 16) & 16'hFFFF;
            m_sq[h] = (m_sq[h] == 1) ? 2 : 0;
          end else begin
            m_e = m_se[h];
            if (m_sq[h] == 2) m_clr = 1;
            m_sq[h] = 0;
          end
        end else if (rd_en) m_sq[h] = 0;
        if (m_clr) begin
          m_lp[h] = m_lp[h] - m_sp[h]; m_le[h] = m_le[h] - m_se[h];
          m_sp[h] = 0; m_se[h] = 0;
        end
        m_lp[h] = (m_lp[h] + m_ep > MAXP) ? MAXP : m_lp[h] + m_ep;
        m_le[h] = (m_le[h] + m_ee > MAXE) ? MAXE : m_le[h] + m_ee;
      end
      if (rd_en && rd_addr == 12'h547) m_e = m_ll << 10;
      if (link_loss) m_ll = (m_ll < 63) ? m_ll + 1 : 63;
      exp_q = m_e;
      m_valid = 1;
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (m_valid && !done) begin
      checks++;
      if (rd_data !== exp_q[15:0]) begin
        failures++;
        $display("FAIL %s model: actual=%h expected=%h", cur_req, rd_data, exp_q[15:0]);
      end
    end
  end

  task automatic check(input logic [15:0] act, input logic [15:0] expv, input string tag);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [15:0] expv, input string tag);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0; rd_addr = '0;
    check(rd_data, expv, tag);
  endtask

  task automatic pulse(input int which, input int n);
    case (which)
      0: tx_pkt_done = 1; 1: tx_pkt_err = 1; 2: rx_pkt_done = 1;
      3: rx_pkt_err = 1;  default: link_loss = 1;
    endcase
    repeat (n) @(negedge clk);
    tx_pkt_done = 0; tx_pkt_err = 0; rx_pkt_done = 0; rx_pkt_err = 0; link_loss = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(rd_data, 16'h0000, "R10 after reset");

    cur_req = "R2";
    pulse(0, 5); pulse(1, 2); pulse(2, 3);
    rd(12'h639, 16'd5, "R2 tx packets");
    rd(12'h63A, 16'd0, "R1 tx high half");
    rd(12'h63B, 16'd2, "R2 tx errors");
    cur_req = "R4";
    rd(12'h639, 16'd0, "R4 tx cleared");
    rd(12'h63A, 16'd0, "R4 tx high");
    rd(12'h63B, 16'd0, "R4 tx errors");

    cur_req = "R3";
    rd(12'h63C, 16'd3, "R2 rx packets");
    pulse(2, 4); pulse(3, 1);
    rd(12'h63D, 16'd0, "R3 frozen high");
    rd(12'h63E, 16'd0, "R3 frozen errors");
    cur_req = "R6";
    rd(12'h63C, 16'd4, "R6 rx kept events");
    rd(12'h63D, 16'd0, "R6 rx high");
    rd(12'h63E, 16'd1, "R6 rx errors kept");

    cur_req = "R5";
    pulse(0, 7);
    rd(12'h639, 16'd7, "R5 seq start");
    rd(12'h63A, 16'd0, "R5 seq second");
    rd(12'h639, 16'd7, "R5 repeated first");
    rd(12'h63A, 16'd0, "R5 second again");
    rd(12'h63B, 16'd0, "R5 third");
    rd(12'h639, 16'd7, "R5 tx not cleared");
    rd(12'h63A, 16'd0, "R4 tx second");
    rd(12'h63B, 16'd0, "R4 tx third");
    rd(12'h639, 16'd0, "R4 tx cleared after plain order");
    pulse(2, 2);
    rd(12'h63C, 16'd2, "R5 rx start");
    rd(12'h700, 16'd0, "R9 unmapped zero");
    rd(12'h63D, 16'd0, "R5 rx second");
    rd(12'h63E, 16'd0, "R5 rx third");
    rd(12'h63C, 16'd2, "R5 rx survived unmapped read");
    rd(12'h63D, 16'd0, "R5 rx second");
    rd(12'h639, 16'd0, "R5 cross-group read");
    rd(12'h63E, 16'd0, "R5 rx third");
    rd(12'h63C, 16'd2, "R5 rx survived cross read");
    rd(12'h63D, 16'd0, "R4 rx second");
    rd(12'h63E, 16'd0, "R4 rx third");
    rd(12'h63C, 16'd0, "R4 rx cleared");

    cur_req = "R7";
    tx_pkt_done = 1; rx_pkt_err = 1;
    repeat (70000) @(negedge clk);
    tx_pkt_done = 0; rx_pkt_err = 0;
    rd(12'h639, 16'h1170, "R1 tx low half");
    rd(12'h63A, 16'h0001, "R1 tx high half");
    rd(12'h63B, 16'h0000, "R1 tx errors");
    rd(12'h63C, 16'h0000, "R2 rx packets untouched");
    rd(12'h63D, 16'h0000, "R1 rx high");
    rd(12'h63E, 16'hFFFF, "R7 rx errors saturate");

    cur_req = "R8";
    pulse(4, 3);
    rd(12'h547, 16'h0C00, "R8 link loss field");
    pulse(4, 67);
    rd(12'h547, 16'hFC00, "R7 link loss saturates");
    rd(12'h547, 16'hFC00, "R8 link loss not cleared");

    cur_req = "R10";
    pulse(0, 2);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    rd(12'h639, 16'h0000, "R10 reset clears");
    rd(12'h547, 16'h0000, "R10 link loss reset");
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
    end
  end
endmodule